// File: doc/BRIEF.md
# Protected Flash Command Sequence Decoder

This block sits beside a parallel flash array and watches the write cycles that a host issues to it. Each write is one pulse on a synchronous strobe carrying an address and a data byte. The block looks for the fixed unlock patterns that must come before any change to the array. When a complete sequence arrives, it emits a one-cycle start pulse for byte program, sector erase or chip erase, together with the latched target address and data.

The block also holds a product-identification mode flag and supplies the two identification bytes for reads in that mode. A write that does not fit the expected pattern silently drops the partial sequence. While the program/erase engine reports busy, every write is ignored. The memory array, the program/erase timer and the electrical bus timing are outside the block.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset no start pulse is active, `id_mode` is 0, `tgt_addr` and `tgt_data` are 0, and no partial sequence is held.
- R2: Every sequence opens with data AA at address 5555 and then data 55 at address 2AAA. Only address bits 14:0 are compared on these cycles, so bit 15 may take either value.
- R3: Prefix, then A0 at 5555, then any fourth write gives `prog_start` high in the cycle after that write's strobe. At the same time `tgt_addr`/`tgt_data` take that write's address and data.
- R4: Prefix, then 80 at 5555, then AA at 5555, then 55 at 2AAA, then 10 at 5555 gives `chip_erase_start` one cycle after the sixth strobe, with `tgt_addr` = 0.
- R5: The same five cycles followed by 30 at any address give `sector_erase_start`. `tgt_addr` holds that address with bits 15:12 kept and bits 11:0 cleared, which is the base of its 4 KB sector.
- R6: A write that does not match the next expected cycle ends the partial sequence and is itself discarded: it is not taken as the opening AA of a new sequence. `id_mode` is left unchanged.
- R7: While `busy` is 1, a write strobe has no effect: it does not move the sequence forward, abort it, start anything or change `id_mode`, and this includes F0 exit writes. A sequence resumes from where it stood once `busy` falls.
- R8: Prefix, then 90 at 5555, sets `id_mode` one cycle after the third strobe.
- R9: `id_mode` is cleared one cycle after either of two writes. One is the prefix followed by F0 at 5555. The other is a lone F0 at any address written while no sequence is in progress.
- R10: `id_data` is BF when `id_mode` is 1, `rd_addr[15:1]` is zero and `rd_addr[0]` is 0. It is B4 under the same conditions with `rd_addr[0]` = 1. In every other case it is 00. The output is combinational from `rd_addr`.
- R11: Start pulses last exactly one cycle and at most one is high at a time. A sequence can restart on the write that immediately follows a completed command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write strobe, one cycle per bus write |
| wr_addr | input | 16 | Write address |
| wr_data | input | 8 | Write data |
| busy | input | 1 | Program/erase engine active |
| rd_addr | input | 16 | Read address for identification bytes |
| id_mode | output | 1 | Product-identification mode flag |
| id_data | output | 8 | Identification byte for `rd_addr` |
| prog_start | output | 1 | Byte program start pulse |
| sector_erase_start | output | 1 | Sector erase start pulse |
| chip_erase_start | output | 1 | Chip erase start pulse |
| tgt_addr | output | 16 | Latched target address |
| tgt_data | output | 8 | Latched program data |

## Verification
The bound checker checks several rules on every cycle. Start pulses are exclusive and last one cycle. No start follows a busy or idle cycle, and `id_mode` holds across busy cycles. A sector start always carries a sector-aligned address, and the identification bytes are quiet outside identification mode. Only the bench scenarios can show that the exact byte and address patterns are recognised, that a wrong cycle is discarded rather than restarting a sequence, and that an interrupted sequence resumes after busy. The bench does this by comparing a queue-based model of the write history against the outputs on every clock, over both directed sequences and a random stream.

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq #(
  parameter int ADDR_W = 16,
  parameter int SECTOR_BITS = 4,
  parameter logic [7:0] MFR_CODE = 8'hBF,
  parameter logic [7:0] DEV_CODE = 8'hB4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              busy,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              id_mode,
  output logic [7:0]        id_data,
  output logic              prog_start,
  output logic              sector_erase_start,
  output logic              chip_erase_start,
  output logic [ADDR_W-1:0] tgt_addr,
  output logic [7:0]        tgt_data
);

  localparam int CMP_W = ADDR_W - 1;
  localparam int OFS_W = ADDR_W - SECTOR_BITS;
  localparam logic [CMP_W-1:0] ADR_A = CMP_W'(15'h5555);
  localparam logic [CMP_W-1:0] ADR_B = CMP_W'(15'h2AAA);

  typedef enum logic [2:0] {
    S_IDLE, S_UL1, S_UL2, S_PROG, S_ER3, S_ER4, S_ER5
  } seq_t;

  seq_t st, st_nx;
  logic id_nx, prog_nx, sect_nx, chip_nx;
  logic [ADDR_W-1:0] addr_nx;
  logic [7:0] data_nx;

  wire take = wr_valid & ~busy;
  wire at_a = (wr_addr[CMP_W-1:0] == ADR_A);
  wire at_b = (wr_addr[CMP_W-1:0] == ADR_B);
  wire cyc_aa = at_a && (wr_data == 8'hAA);
  wire cyc_55 = at_b && (wr_data == 8'h55);
  wire [ADDR_W-1:0] sect_base = {wr_addr[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};

  always_comb begin
    st_nx   = st;
    id_nx   = id_mode;
    prog_nx = 1'b0;
    sect_nx = 1'b0;
    chip_nx = 1'b0;
    addr_nx = tgt_addr;
    data_nx = tgt_data;
    if (take) begin
      st_nx = S_IDLE;
      case (st)
        S_IDLE: begin
          if (cyc_aa) st_nx = S_UL1;
          else if (wr_data == 8'hF0) id_nx = 1'b0;
        end
        S_UL1: if (cyc_55) st_nx = S_UL2;
        S_UL2: if (at_a) begin
          case (wr_data)
            8'hA0: st_nx = S_PROG;
            8'h80: st_nx = S_ER3;
            8'h90: id_nx = 1'b1;
            8'hF0: id_nx = 1'b0;
            default: ;
          endcase
        end
        S_PROG: begin
          prog_nx = 1'b1;
          addr_nx = wr_addr;
          data_nx = wr_data;
        end
        S_ER3: if (cyc_aa) st_nx = S_ER4;
        S_ER4: if (cyc_55) st_nx = S_ER5;
        S_ER5: begin
          if (at_a && wr_data == 8'h10) begin
            chip_nx = 1'b1;
            addr_nx = '0;
          end else if (wr_data == 8'h30) begin
            sect_nx = 1'b1;
            addr_nx = sect_base;
          end
        end
        default: st_nx = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st                 <= S_IDLE;
      id_mode            <= 1'b0;
      prog_start         <= 1'b0;
      sector_erase_start <= 1'b0;
      chip_erase_start   <= 1'b0;
      tgt_addr           <= '0;
      tgt_data           <= '0;
    end else begin
      st                 <= st_nx;
      id_mode            <= id_nx;
      prog_start         <= prog_nx;
      sector_erase_start <= sect_nx;
      chip_erase_start   <= chip_nx;
      tgt_addr           <= addr_nx;
      tgt_data           <= data_nx;
    end
  end

  assign id_data = (id_mode && rd_addr[ADDR_W-1:1] == '0)
                   ? (rd_addr[0] ? DEV_CODE : MFR_CODE) : 8'h00;

endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk #(
  parameter int ADDR_W = 16,
  parameter int SECTOR_BITS = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic              busy,
  input logic              id_mode,
  input logic [7:0]        id_data,
  input logic              prog_start,
  input logic              sector_erase_start,
  input logic              chip_erase_start,
  input logic [ADDR_W-1:0] tgt_addr
);
  localparam int OFS_W = ADDR_W - SECTOR_BITS;
  wire any_start = prog_start | sector_erase_start | chip_erase_start;

  AST_START_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prog_start, sector_erase_start, chip_erase_start})); // R11
  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    any_start |=> !any_start); // R11
  AST_BUSY_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !any_start); // R7
  AST_IDLE_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |=> !any_start); // R11
  AST_BUSY_ID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(id_mode)); // R7
  AST_SECTOR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    sector_erase_start |-> tgt_addr[OFS_W-1:0] == '0); // R5
  AST_CHIP_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    chip_erase_start |-> tgt_addr == '0); // R4
  AST_ID_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !id_mode |-> id_data == 8'h00); // R10
endmodule

bind flash_cmd_seq flash_cmd_seq_chk #(.ADDR_W(ADDR_W), .SECTOR_BITS(SECTOR_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .busy(busy),
  .id_mode(id_mode), .id_data(id_data), .prog_start(prog_start),
  .sector_erase_start(sector_erase_start), .chip_erase_start(chip_erase_start),
  .tgt_addr(tgt_addr)
);

// File: tb/tb_flash_cmd_seq.sv
module tb_flash_cmd_seq;
  localparam int PERIOD = 10;

  logic clk = 0, rst_n = 0, wr_valid = 0, busy = 0;
  logic [15:0] wr_addr = 0, rd_addr = 0;
  logic [7:0] wr_data = 0;
  logic id_mode, prog_start, sector_erase_start, chip_erase_start;
  logic [7:0] id_data, tgt_data;
  logic [15:0] tgt_addr;

  flash_cmd_seq dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .busy(busy), .rd_addr(rd_addr), .id_mode(id_mode),
    .id_data(id_data), .prog_start(prog_start),
    .sector_erase_start(sector_erase_start), .chip_erase_start(chip_erase_start),
    .tgt_addr(tgt_addr), .tgt_data(tgt_data)
  );

  always #(PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  string cur_req = "R1";
  bit done = 0;

  typedef struct { logic [15:0] a; logic [7:0] d; } wr_t;
  wr_t hist[$];
  bit e_id, e_prog, e_sect, e_chip;
  logic [15:0] e_addr;
  logic [7:0] e_data;

  function automatic bit at(int i, logic [14:0] v);
    return hist[i].a[14:0] == v;
  endfunction

  // returns 1 when the history is a live prefix of some command
  function automatic bit judge();
    int n = hist.size();
    case (n)
      1: begin
        if (at(0, 15'h5555) && hist[0].d == 8'hAA) return 1;
        if (hist[0].d == 8'hF0) e_id = 0;
        return 0;
      end
      2: return at(1, 15'h2AAA) && hist[1].d == 8'h55;
      3: begin
        if (!at(2, 15'h5555)) return 0;
        if (hist[2].d == 8'hA0 || hist[2].d == 8'h80) return 1;
        if (hist[2].d == 8'h90) e_id = 1;
        if (hist[2].d == 8'hF0) e_id = 0;
        return 0;
      end
      4: begin
        if (hist[2].d == 8'hA0) begin
          e_prog = 1; e_addr = hist[3].a; e_data = hist[3].d;
          return 0;
        end
        return at(3, 15'h5555) && hist[3].d == 8'hAA;
      end
      5: return at(4, 15'h2AAA) && hist[4].d == 8'h55;
      6: begin
        if (at(5, 15'h5555) && hist[5].d == 8'h10) begin
          e_chip = 1; e_addr = 16'h0000;
        end else if (hist[5].d == 8'h30) begin
          e_sect = 1; e_addr = {hist[5].a[15:12], 12'h000};
        end
        return 0;
      end
      default: return 0;
    endcase
  endfunction

  task automatic cmp(string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    e_prog = 0; e_sect = 0; e_chip = 0;
    if (!rst_n) begin
      hist.delete(); e_id = 0; e_addr = 0; e_data = 0;
    end else if (wr_valid && !busy) begin
      hist.push_back('{wr_addr, wr_data});
      if (!judge()) hist.delete();
    end
    #(PERIOD/4);
    if (!done) begin
      cmp("prog_start", 16'(prog_start), 16'(e_prog));
      cmp("sector_erase_start", 16'(sector_erase_start), 16'(e_sect));
      cmp("chip_erase_start", 16'(chip_erase_start), 16'(e_chip));
      cmp("id_mode", 16'(id_mode), 16'(e_id));
      cmp("tgt_addr", tgt_addr, e_addr);
      cmp("tgt_data", 16'(tgt_data), 16'(e_data));
      cmp("id_data", 16'(id_data),
          (e_id && rd_addr[15:1] == 0) ? (rd_addr[0] ? 16'hB4 : 16'hBF) : 16'h0);
    end
  end

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); wr_valid = 1; wr_addr = a; wr_data = d;
  endtask
  task automatic idle(input int n);
    repeat (n) begin @(negedge clk); wr_valid = 0; end
  endtask
  task automatic unlock();
    wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55);
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    cur_req = "R1";
    idle(3); rst_n = 1; idle(2);
    cur_req = "R10"; rd_addr = 0; idle(1); rd_addr = 1; idle(1);

    cur_req = "R2"; // bit 15 set on unlock addresses
    wr(16'hD555, 8'hAA); wr(16'hAAAA, 8'h55); wr(16'hD555, 8'hA0); wr(16'h1234, 8'h5A); idle(2);
    cur_req = "R3";
    unlock(); wr(16'h5555, 8'hA0); idle(2); wr(16'hFFFF, 8'hC3); idle(2);
    cur_req = "R4";
    unlock(); wr(16'h5555, 8'h80); unlock(); wr(16'h5555, 8'h10); idle(2);
    cur_req = "R5";
    unlock(); wr(16'h5555, 8'h80); unlock(); wr(16'h7ABC, 8'h30); idle(2);
    unlock(); wr(16'h5555, 8'h80); unlock(); wr(16'hF001, 8'h30); idle(2);
    cur_req = "R6";
    wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h56); wr(16'h2AAA, 8'h55); wr(16'h5555, 8'hA0); wr(16'h0100, 8'h12); idle(2);
    wr(16'h5555, 8'hAA); wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55); wr(16'h5555, 8'hA0); wr(16'h0101, 8'h13); idle(2);
    unlock(); wr(16'h5555, 8'h80); unlock(); wr(16'h5555, 8'h20); idle(2);
    unlock(); wr(16'h5554, 8'hA0); wr(16'h0102, 8'h14); idle(2);
    cur_req = "R8";
    unlock(); wr(16'h5555, 8'h90); idle(1);
    cur_req = "R10";
    rd_addr = 0; idle(1); rd_addr = 1; idle(1); rd_addr = 2; idle(1); rd_addr = 16'h8000; idle(1); rd_addr = 16'h8001; idle(1);
    cur_req = "R6"; // abort keeps ID mode
    wr(16'h5555, 8'hAA); wr(16'h1111, 8'h00); idle(2);
    cur_req = "R9";
    rd_addr = 1; wr(16'h1234, 8'hF0); idle(2);
    unlock(); wr(16'h5555, 8'h90); idle(2);
    unlock(); wr(16'h5555, 8'hF0); idle(2);
    cur_req = "R7";
    unlock(); wr(16'h5555, 8'h90); idle(1);
    busy = 1; wr(16'h0000, 8'hF0); wr(16'h5555, 8'hAA); idle(1); busy = 0; idle(2);
    unlock(); busy = 1; wr(16'h9999, 8'h77); wr(16'h5555, 8'hF0); idle(1); busy = 0;
    wr(16'h5555, 8'hA0); busy = 1; wr(16'h0300, 8'h11); busy = 0; wr(16'h0400, 8'h22); idle(3);
    cur_req = "R11";
    unlock(); wr(16'h5555, 8'hA0); wr(16'h0500, 8'h33);
    unlock(); wr(16'h5555, 8'hA0); wr(16'h0600, 8'h44);
    unlock(); wr(16'h5555, 8'h80); unlock(); wr(16'h3FFF, 8'h30);
    wr(16'h0000, 8'hF0); idle(3);

    cur_req = "R11";
    for (int i = 0; i < 6000; i++) begin
      logic [15:0] aa [5] = '{16'h5555, 16'h2AAA, 16'hD555, 16'hAAAA, 16'h0000};
      logic [7:0] dd [9] = '{8'hAA, 8'h55, 8'hA0, 8'h80, 8'h90, 8'hF0, 8'h10, 8'h30, 8'h00};
      @(negedge clk);
      wr_valid = ($urandom % 4) != 0;
      wr_addr = ($urandom % 4 == 0) ? 16'($urandom) : aa[$urandom % 5];
      wr_data = ($urandom % 8 == 0) ? 8'($urandom) : dd[$urandom % 9];
      busy = ($urandom % 7) == 0;
      rd_addr = 16'($urandom % 3);
      if (i % 500 == 250) begin
        busy = 0; unlock(); wr(16'h5555, 8'h80); unlock(); wr(16'($urandom), 8'h30);
      end
    end
    busy = 0; idle(3);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule